// File: doc/BRIEF.md
# SPI FIFO Level, Interrupt and DMA Request Unit

This unit sits between the register port of an SPI controller and its serial engine. It holds the transmit and receive FIFOs and counts their fill levels. It compares those levels against programmable thresholds and watermarks. From that it produces a status word, a set of maskable interrupt sources and two independent DMA request lines, one that asks for more transmit data and one that asks for receive data to be drained.

Software pushes transmit words and pops receive words through single-cycle register writes and reads. The serial engine pops transmit words and pushes received words through strobes. The threshold registers only keep a value below the FIFO depth. Software can therefore find the depth by writing rising values from 2 upward and stopping at the first value that does not read back.

Top module: `spi_fifo_irq_dma`

## Requirements
- R1: After reset both FIFOs are empty. Thresholds, watermarks, the interrupt mask and the DMA control register are zero, and no error flag is set. `irq`, `tx_dma_req` and `rx_dma_req` are low, and the raw interrupt register (index 8) reads 1.
- R2: A write to index 0 pushes `reg_wdata[DATA_W-1:0]` into the TX FIFO. `eng_tx_data` shows the oldest entry, and `eng_tx_pop` removes it, so words leave in first-in first-out order. An engine pop of an empty TX FIFO changes nothing and sets no flag.
- R3: A push to a full FIFO with no pop in the same cycle drops the word and leaves the level unchanged. A dropped TX write sets raw bit1 (TX overflow). A dropped `eng_rx_push` sets raw bit3 (RX overflow).
- R4: A read of index 1 with `reg_rd` high returns the oldest RX word and pops it. When the RX FIFO is empty the read returns 0, leaves the level at 0 and sets raw bit2 (RX underflow).
- R5: Index 4 reads the TX level and index 5 reads the RX level. Each level runs from 0 to DEPTH.
- R6: The status word at index 6 has these bits:
  - bit0: busy, meaning `eng_busy` or a non-empty TX FIFO.
  - bit1: TX full.
  - bit2: TX empty.
  - bit3: RX empty.
  - bit4: RX full.
- R7: The TX threshold (index 2) and RX threshold (index 3) take a write only when the value is below DEPTH. Otherwise they keep their previous value. Reading back rising values from 2 first fails at DEPTH.
- R8: The raw interrupt register (index 8) has these bits:
  - bit0: TX level at or below the TX threshold.
  - bit1: TX overflow.
  - bit2: RX underflow.
  - bit3: RX overflow.
  - bit4: RX level above the RX threshold.
  
  The mask is at index 7. The masked register (index 9) is raw AND mask, and `irq` is the OR of the masked bits.
- R9: A write to index 10 clears flags as follows:
  - bit0: clears all three error flags.
  - bit1: clears RX underflow.
  - bit2: clears RX overflow.
  - bit3: clears TX overflow.
  
  An error event in the same cycle as its clear leaves the flag set. Error flags otherwise stay set until cleared.
- R10: In the DMA control register (index 11), bit0 enables RX requests and bit1 enables TX requests. `tx_dma_req` is high when TX is enabled and the TX level is at or below the TX watermark (index 12). `rx_dma_req` is high when RX is enabled and the RX level is above the RX watermark (index 13).
- R11: A push and a pop of the same full FIFO in one cycle both take effect. The level stays at DEPTH and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX at index 1) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| eng_busy | input | 1 | Serial engine is shifting |
| eng_tx_pop | input | 1 | Engine takes the oldest TX word |
| eng_tx_data | output | DATA_W | Oldest TX word (0 when empty) |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| irq | output | 1 | OR of masked interrupt sources |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |

## Verification
The bench drives the unit in these corner cases:
- Pushing into a full FIFO and popping an empty one. A design that counted the dropped word would report a level of DEPTH+1 or corrupt the order.
- Push and pop of a full FIFO in the same cycle. A design that judged "full" without the pop would drop a word and raise a false overflow.
- An error event that lands in the cycle its clear is written. A design with clear taking priority would lose the event silently.
- The depth probe on the threshold registers and the level comparisons one entry either side of each threshold and watermark. Off-by-one comparisons would move an interrupt or DMA request by one entry.

// File: rtl/sfid_pkg.sv
package sfid_pkg;

    localparam int REG_AW = 4;
    localparam int IRQ_W  = 5;

    typedef enum logic [REG_AW-1:0] {
        RG_TXDATA = 4'd0,
        RG_RXDATA = 4'd1,
        RG_TXTHR  = 4'd2,
        RG_RXTHR  = 4'd3,
        RG_TXLVL  = 4'd4,
        RG_RXLVL  = 4'd5,
        RG_STAT   = 4'd6,
        RG_IMASK  = 4'd7,
        RG_IRAW   = 4'd8,
        RG_IMST   = 4'd9,
        RG_ICLR   = 4'd10,
        RG_DMACTL = 4'd11,
        RG_TXWM   = 4'd12,
        RG_RXWM   = 4'd13
    } sfid_reg_e;

    // interrupt bit positions
    localparam int IB_TXLOW  = 0;
    localparam int IB_TXOVF  = 1;
    localparam int IB_RXUND  = 2;
    localparam int IB_RXOVF  = 3;
    localparam int IB_RXHIGH = 4;

    // status bit positions
    localparam int SB_BUSY    = 0;
    localparam int SB_TXFULL  = 1;
    localparam int SB_TXEMPTY = 2;
    localparam int SB_RXEMPTY = 3;
    localparam int SB_RXFULL  = 4;

    // clear register bit positions
    localparam int CB_ALL   = 0;
    localparam int CB_RXUND = 1;
    localparam int CB_RXOVF = 2;
    localparam int CB_TXOVF = 3;

    // DMA control bit positions
    localparam int DB_RX = 0;
    localparam int DB_TX = 1;

    typedef struct packed {
        logic tx_ovf;
        logic rx_und;
        logic rx_ovf;
    } sfid_sticky_t;

endpackage

// File: rtl/sfid_fifo.sv
module sfid_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              ovf_evt,
    output logic              und_evt
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [LVL_W-1:0] level;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full  = (st_q.level == LVL_W'(DEPTH));
    assign empty = (st_q.level == '0);
    assign level = st_q.level;
    assign head  = empty ? '0 : mem_q[st_q.rd_ptr];

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        ovf_evt = push && !push_ok;
        und_evt = pop && empty;
        if (push_ok) st_d.wr_ptr = ptr_next(st_q.wr_ptr);
        if (pop_ok)  st_d.rd_ptr = ptr_next(st_q.rd_ptr);
        st_d.level = st_q.level + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr_ptr] <= push_data;
    end

    p_level_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.level <= LVL_W'(DEPTH));

    p_drop_keeps_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (st_q.level == $past(st_q.level)));

    p_level_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(st_q.level));

endmodule

// File: rtl/sfid_irq.sv
module sfid_irq
    import sfid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_low,
    input  logic             rx_high,
    input  logic             tx_ovf_evt,
    input  logic             rx_und_evt,
    input  logic             rx_ovf_evt,
    input  logic             clr_wr,
    input  logic [3:0]       clr_bits,
    input  logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);

    sfid_sticky_t stk_d, stk_q, clr, evt;

    always_comb begin
        clr.tx_ovf = clr_wr && (clr_bits[CB_ALL] || clr_bits[CB_TXOVF]);
        clr.rx_und = clr_wr && (clr_bits[CB_ALL] || clr_bits[CB_RXUND]);
        clr.rx_ovf = clr_wr && (clr_bits[CB_ALL] || clr_bits[CB_RXOVF]);
        evt.tx_ovf = tx_ovf_evt;
        evt.rx_und = rx_und_evt;
        evt.rx_ovf = rx_ovf_evt;
        // a new event outranks a clear in the same cycle
        stk_d = (stk_q & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    always_comb begin
        raw            = '0;
        raw[IB_TXLOW]  = tx_low;
        raw[IB_TXOVF]  = stk_q.tx_ovf;
        raw[IB_RXUND]  = stk_q.rx_und;
        raw[IB_RXOVF]  = stk_q.rx_ovf;
        raw[IB_RXHIGH] = rx_high;
        masked         = raw & mask;
        irq            = |masked;
    end

    p_sticky_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr) |=> ((stk_q & $past(stk_q)) == $past(stk_q)));

    p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf_evt |=> raw[IB_TXOVF]);

endmodule

// File: rtl/spi_fifo_irq_dma.sv
module spi_fifo_irq_dma
    import sfid_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              eng_busy,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [LVL_W-1:0] tx_thr;
        logic [LVL_W-1:0] rx_thr;
        logic [LVL_W-1:0] tx_wm;
        logic [LVL_W-1:0] rx_wm;
        logic [IRQ_W-1:0] imask;
        logic [1:0]       dmactl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    sfid_reg_e addr;

    logic wr_tx, rd_rx, clr_wr, thr_ok;
    logic [DATA_W-1:0] rx_head;
    logic [LVL_W-1:0]  tx_lvl, rx_lvl;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_ovf_evt, tx_und_evt, rx_ovf_evt, rx_und_evt;
    logic [IRQ_W-1:0] raw, masked, status;

    assign addr   = sfid_reg_e'(reg_addr);
    assign wr_tx  = reg_wr && (addr == RG_TXDATA);
    assign rd_rx  = reg_rd && (addr == RG_RXDATA);
    assign clr_wr = reg_wr && (addr == RG_ICLR);
    assign thr_ok = (reg_wdata < 32'(DEPTH));

    sfid_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_txf (
        .clk(clk), .rst_n(rst_n),
        .push(wr_tx), .push_data(reg_wdata[DATA_W-1:0]),
        .pop(eng_tx_pop), .head(eng_tx_data),
        .level(tx_lvl), .full(tx_full), .empty(tx_empty),
        .ovf_evt(tx_ovf_evt), .und_evt(tx_und_evt)
    );

    sfid_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rxf (
        .clk(clk), .rst_n(rst_n),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(rd_rx), .head(rx_head),
        .level(rx_lvl), .full(rx_full), .empty(rx_empty),
        .ovf_evt(rx_ovf_evt), .und_evt(rx_und_evt)
    );

    sfid_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_low(tx_lvl <= cfg_q.tx_thr),
        .rx_high(rx_lvl > cfg_q.rx_thr),
        .tx_ovf_evt(tx_ovf_evt),
        .rx_und_evt(rx_und_evt),
        .rx_ovf_evt(rx_ovf_evt),
        .clr_wr(clr_wr),
        .clr_bits(reg_wdata[3:0]),
        .mask(cfg_q.imask),
        .raw(raw), .masked(masked), .irq(irq)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            case (addr)
                RG_TXTHR:  if (thr_ok) cfg_d.tx_thr = reg_wdata[LVL_W-1:0];
                RG_RXTHR:  if (thr_ok) cfg_d.rx_thr = reg_wdata[LVL_W-1:0];
                RG_TXWM:   cfg_d.tx_wm  = reg_wdata[LVL_W-1:0];
                RG_RXWM:   cfg_d.rx_wm  = reg_wdata[LVL_W-1:0];
                RG_IMASK:  cfg_d.imask  = reg_wdata[IRQ_W-1:0];
                RG_DMACTL: cfg_d.dmactl = reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        status             = '0;
        status[SB_BUSY]    = eng_busy || !tx_empty;
        status[SB_TXFULL]  = tx_full;
        status[SB_TXEMPTY] = tx_empty;
        status[SB_RXEMPTY] = rx_empty;
        status[SB_RXFULL]  = rx_full;
    end

    assign tx_dma_req = cfg_q.dmactl[DB_TX] && (tx_lvl <= cfg_q.tx_wm);
    assign rx_dma_req = cfg_q.dmactl[DB_RX] && (rx_lvl > cfg_q.rx_wm);

    always_comb begin
        reg_rdata = '0;
        case (addr)
            RG_RXDATA: reg_rdata = 32'(rx_head);
            RG_TXTHR:  reg_rdata = 32'(cfg_q.tx_thr);
            RG_RXTHR:  reg_rdata = 32'(cfg_q.rx_thr);
            RG_TXLVL:  reg_rdata = 32'(tx_lvl);
            RG_RXLVL:  reg_rdata = 32'(rx_lvl);
            RG_STAT:   reg_rdata = 32'(status);
            RG_IMASK:  reg_rdata = 32'(cfg_q.imask);
            RG_IRAW:   reg_rdata = 32'(raw);
            RG_IMST:   reg_rdata = 32'(masked);
            RG_DMACTL: reg_rdata = 32'(cfg_q.dmactl);
            RG_TXWM:   reg_rdata = 32'(cfg_q.tx_wm);
            RG_RXWM:   reg_rdata = 32'(cfg_q.rx_wm);
            default:   reg_rdata = '0;
        endcase
    end

    p_thr_below_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.tx_thr < LVL_W'(DEPTH)) && (cfg_q.rx_thr < LVL_W'(DEPTH)));

    p_und_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && rx_empty) |=> raw[IB_RXUND]);

    p_irq_quiet_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.imask == '0) |-> !irq);

    p_txreq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_q.dmactl[DB_TX]) |-> !tx_dma_req);

    p_tx_pop_empty_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_pop && tx_empty && !wr_tx) |=> (tx_lvl == '0));

endmodule

// File: tb/spi_fifo_irq_dma_test.sv
module spi_fifo_irq_dma_test;
    import sfid_pkg::*;

    localparam int DEPTH  = 8;
    localparam int DATA_W = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [3:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic eng_busy = 0, eng_tx_pop = 0, eng_rx_push = 0;
    logic [DATA_W-1:0] eng_tx_data;
    logic [DATA_W-1:0] eng_rx_data = 0;
    logic irq, tx_dma_req, rx_dma_req;

    always #10 clk = ~clk;

    spi_fifo_irq_dma #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_busy(eng_busy), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    logic [DATA_W-1:0] txq[$];
    logic [DATA_W-1:0] rxq[$];
    int m_txthr = 0, m_rxthr = 0, m_txwm = 0, m_rxwm = 0;
    int m_mask = 0, m_dma = 0;
    bit m_txovf = 0, m_rxund = 0, m_rxovf = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] m_raw();
        logic [4:0] r;
        r[0] = (txq.size() <= m_txthr);
        r[1] = m_txovf;
        r[2] = m_rxund;
        r[3] = m_rxovf;
        r[4] = (rxq.size() > m_rxthr);
        return r;
    endfunction

    function automatic logic [31:0] m_rd(input int a);
        logic [4:0] s;
        case (a)
            1:  return (rxq.size() > 0) ? 32'(rxq[0]) : 32'h0;
            2:  return 32'(m_txthr);
            3:  return 32'(m_rxthr);
            4:  return 32'(txq.size());
            5:  return 32'(rxq.size());
            6: begin
                s[0] = eng_busy || (txq.size() != 0);
                s[1] = (txq.size() == DEPTH);
                s[2] = (txq.size() == 0);
                s[3] = (rxq.size() == 0);
                s[4] = (rxq.size() == DEPTH);
                return 32'(s);
            end
            7:  return 32'(m_mask);
            8:  return 32'(m_raw());
            9:  return 32'(m_raw() & 5'(m_mask));
            11: return 32'(m_dma);
            12: return 32'(m_txwm);
            13: return 32'(m_rxwm);
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_update();
        bit tx_full_b, rx_empty_b, rx_full_b, tx_pop, rx_pop;
        bit s_txovf, s_rxund, s_rxovf, c_tx, c_und, c_rxo;
        tx_full_b  = (txq.size() == DEPTH);
        rx_empty_b = (rxq.size() == 0);
        rx_full_b  = (rxq.size() == DEPTH);
        tx_pop = eng_tx_pop && (txq.size() > 0);
        rx_pop = reg_rd && (reg_addr == 4'd1) && !rx_empty_b;
        s_txovf = 0; s_rxund = 0; s_rxovf = 0;
        if (tx_pop) void'(txq.pop_front());
        if (rx_pop) void'(rxq.pop_front());
        if (reg_rd && reg_addr == 4'd1 && rx_empty_b) s_rxund = 1;
        if (reg_wr && reg_addr == 4'd0) begin
            if (tx_full_b && !tx_pop) s_txovf = 1;
            else txq.push_back(reg_wdata[DATA_W-1:0]);
        end
        if (eng_rx_push) begin
            if (rx_full_b && !rx_pop) s_rxovf = 1;
            else rxq.push_back(eng_rx_data);
        end
        c_tx = 0; c_und = 0; c_rxo = 0;
        if (reg_wr) begin
            case (reg_addr)
                4'd2:  if (reg_wdata < DEPTH) m_txthr = int'(reg_wdata);
                4'd3:  if (reg_wdata < DEPTH) m_rxthr = int'(reg_wdata);
                4'd7:  m_mask = int'(reg_wdata[4:0]);
                4'd10: begin
                    c_tx  = reg_wdata[0] | reg_wdata[3];
                    c_und = reg_wdata[0] | reg_wdata[1];
                    c_rxo = reg_wdata[0] | reg_wdata[2];
                end
                4'd11: m_dma  = int'(reg_wdata[1:0]);
                4'd12: m_txwm = int'(reg_wdata[3:0]);
                4'd13: m_rxwm = int'(reg_wdata[3:0]);
                default: ;
            endcase
        end
        m_txovf = (m_txovf & !c_tx)  | s_txovf;
        m_rxund = (m_rxund & !c_und) | s_rxund;
        m_rxovf = (m_rxovf & !c_rxo) | s_rxovf;
    endtask

    task automatic compare();
        chk("R8 irq pin", 32'(irq), 32'(|(m_raw() & 5'(m_mask))));
        chk("R10 tx_dma_req", 32'(tx_dma_req), 32'(m_dma[1] && (txq.size() <= m_txwm)));
        chk("R10 rx_dma_req", 32'(rx_dma_req), 32'(m_dma[0] && (rxq.size() > m_rxwm)));
        chk("R2 tx head", 32'(eng_tx_data), (txq.size() > 0) ? 32'(txq[0]) : 32'h0);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        reg_wr = 0; reg_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_addr = 4'(a); reg_wdata = d; reg_wr = 1;
        cyc();
    endtask

    task automatic rd(input int a, input string tag, output logic [31:0] v);
        reg_addr = 4'(a); reg_rd = 1;
        #1;
        chk(tag, reg_rdata, m_rd(a));
        v = reg_rdata;
        cyc();
    endtask

    task automatic rx_in(input logic [DATA_W-1:0] d);
        eng_rx_data = d; eng_rx_push = 1;
        cyc();
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int found;
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        compare();
        chk("R1 irq low", 32'(irq), 0);
        chk("R1 tx_dma_req low", 32'(tx_dma_req), 0);
        rd(8, "R1 raw", v);   chk("R1 raw after reset", v, 32'h1);
        rd(4, "R1 txlvl", v); chk("R1 txlvl zero", v, 0);
        rd(5, "R1 rxlvl", v); chk("R1 rxlvl zero", v, 0);
        rd(6, "R1 status", v); chk("R1 status empties", v, 32'h0C);
        rd(11, "R1 dmactl", v); chk("R1 dmactl zero", v, 0);

        // R7 depth probe through the threshold register
        found = 0;
        for (int k = 2; k < 32; k++) begin
            wr(2, 32'(k));
            rd(2, "R7 probe readback", v);
            if (v != 32'(k) && found == 0) found = k;
        end
        chk("R7 probed depth", 32'(found), 32'(DEPTH));
        wr(3, 32'd20);
        rd(3, "R7 rx thr ignored", v); chk("R7 rx thr kept", v, 0);
        wr(2, 32'd3); wr(3, 32'd2);

        // R2 TX order and empty pop
        wr(0, 32'hA001); wr(0, 32'hA002); wr(0, 32'h1_A003);
        rd(4, "R5 txlvl 3", v); chk("R5 txlvl three", v, 3);
        eng_busy = 1;
        rd(6, "R6 status busy", v);
        eng_busy = 0;
        chk("R2 first out", 32'(eng_tx_data), 32'hA001);
        for (int k = 0; k < 4; k++) begin eng_tx_pop = 1; cyc(); end
        rd(8, "R2 empty pop no flag", v); chk("R2 no tx ovf", v & 32'h2, 0);

        // R3 TX overflow, R11 simultaneous push+pop on full
        for (int k = 0; k < DEPTH + 1; k++) wr(0, 32'(16'hB000 + k));
        rd(4, "R3 txlvl full", v); chk("R3 level held at depth", v, DEPTH);
        rd(8, "R3 tx ovf raw", v); chk("R3 tx ovf bit1", v & 32'h2, 32'h2);
        rd(6, "R6 status txfull", v);
        reg_addr = 4'd0; reg_wdata = 32'hC0DE; reg_wr = 1; eng_tx_pop = 1; cyc();
        rd(4, "R11 txlvl", v); chk("R11 level unchanged", v, DEPTH);
        wr(10, 32'h8);
        rd(8, "R11 no new ovf", v); chk("R11 tx ovf clear", v & 32'h2, 0);
        for (int k = 0; k < DEPTH; k++) begin eng_tx_pop = 1; cyc(); end

        // R3 RX overflow, R4 read order and underflow
        for (int k = 0; k < DEPTH + 1; k++) rx_in(16'h5000 + 16'(k));
        rd(5, "R5 rxlvl full", v); chk("R5 rx at depth", v, DEPTH);
        rd(6, "R6 status rxfull", v);
        rd(8, "R3 rx ovf raw", v); chk("R3 rx ovf bit3", v & 32'h8, 32'h8);
        for (int k = 0; k < DEPTH; k++) begin
            rd(1, "R4 rx data", v); chk("R4 rx order", v, 32'(16'h5000 + k));
        end
        rd(1, "R4 empty read", v); chk("R4 empty reads zero", v, 0);
        rd(8, "R4 und raw", v); chk("R4 und bit2", v & 32'h4, 32'h4);
        rd(5, "R4 rxlvl zero", v); chk("R4 level stays 0", v, 0);

        // R9 clears and set-with-clear
        wr(10, 32'h2);
        rd(8, "R9 und cleared", v); chk("R9 und gone ovf kept", v & 32'hC, 32'h8);
        for (int k = 0; k < DEPTH; k++) rx_in(16'h6000 + 16'(k));
        reg_addr = 4'd10; reg_wdata = 32'h4; reg_wr = 1;
        eng_rx_data = 16'hDEAD; eng_rx_push = 1; cyc();
        rd(8, "R9 set beats clear", v); chk("R9 rx ovf still set", v & 32'h8, 32'h8);
        wr(10, 32'h1);
        rd(8, "R9 clear all", v); chk("R9 all errors cleared", v & 32'hE, 0);

        // R8 mask and irq
        wr(7, 32'h10);
        rd(9, "R8 masked", v); chk("R8 masked rxhigh", v, 32'h10);
        chk("R8 irq on", 32'(irq), 1);
        wr(7, 32'h02);
        chk("R8 irq off", 32'(irq), 0);
        wr(7, 32'h1F);
        rd(9, "R8 masked all", v);
        for (int k = 0; k < DEPTH; k++) rd(1, "R4 drain", v);

        // R10 DMA requests around watermarks
        wr(12, 32'd2); wr(13, 32'd3); wr(11, 32'h3);
        chk("R10 tx req at 0", 32'(tx_dma_req), 1);
        for (int k = 0; k < 4; k++) wr(0, 32'(k));
        chk("R10 tx req off above wm", 32'(tx_dma_req), 0);
        for (int k = 0; k < 5; k++) rx_in(16'(k));
        chk("R10 rx req on above wm", 32'(rx_dma_req), 1);
        rd(1, "R10 rx pop", v); rd(1, "R10 rx pop", v);
        chk("R10 rx req off at wm", 32'(rx_dma_req), 0);
        wr(11, 32'h0);
        chk("R10 tx disabled", 32'(tx_dma_req), 0);
        wr(11, 32'h3);

        // mixed traffic against the model
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            eng_tx_pop  = lfsr[0];
            eng_rx_push = lfsr[1] & lfsr[2];
            eng_rx_data = lfsr;
            eng_busy    = lfsr[9];
            if (lfsr[3]) begin
                reg_addr = 4'd0; reg_wdata = 32'(lfsr); reg_wr = 1; cyc();
            end else if (lfsr[4]) begin
                rd(int'(lfsr[7:5]) % 2 == 0 ? 1 : 6, "R4 R6 mixed read", v);
            end else if (lfsr[8] && lfsr[11]) begin
                wr(10, 32'(lfsr[15:12]));
            end else begin
                cyc();
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule